// File: doc/BRIEF.md
# Host Serial Handshake Controller

This block is a byte-wide synchronous serial port where the peripheral, not the host microcontroller, owns the serial clock. The host asks for service on one of two request lines by raising it.

A rising edge on the byte-ready line means the host has loaded a data byte. The block then clocks that byte in over the serial input.

A rising edge on the status-request line starts a full-duplex swap. The host's control byte comes in while the block's status byte goes out.

During a transfer the block drives the serial clock and serial output, and it pulls an active-low bus-active flag low. At all other times it releases both drivers; each has its own enable pin. Every received byte appears on a parallel output with a one-cycle valid strobe and a tag that says whether it is data or control.

After reset, data fetches stay on hold until one status/control swap has completed. A sticky flag reports that event, so the surrounding logic can keep its network side inhibited until the host has reinitialised the block.

Top module: `hsh_ctrl`

## Requirements
- R1: While reset is held and right after it: bus_act_n_o=1, sck_oe_o=0, sout_oe_o=0, sck_o=0, rx_valid_o=0, init_done_o=0.
- R2: After a rising edge on byte_rdy_i, the block fetches one byte. SIN is sampled on each rising SCK, the first bit is the MSB, and the byte appears on rx_data_o with rx_valid_o=1 and rx_is_ctrl_o=0.
- R3: After a rising edge on stat_req_i, the block runs a swap. SOUT carries the status byte MSB first and changes only while SCK is low, never while it is high. The received byte is tagged rx_is_ctrl_o=1.
- R4: Every transfer has exactly 8 SCK high pulses. SCK is low when the transfer starts and is held low whenever its driver is released.
- R5: sck_oe_o and sout_oe_o are 1 only while a transfer runs, and bus_act_n_o is 0 for exactly those cycles.
- R6: A byte-ready edge that arrives before init_done_o is 1 starts no transfer. It is held pending and served once the first swap completes.
- R7: init_done_o rises in the same cycle as the rx_valid_o of the first completed swap. It stays 1 until reset, and a reset clears it.
- R8: When both requests are pending, the swap is served before the data fetch.
- R9: The status byte is captured when a swap starts, so later changes on status_i do not alter the bits sent.
- R10: rx_valid_o is never high for two consecutive cycles.
- R11: A request edge that arrives during a transfer is remembered and served after it.
- R12: A request held high starts only one transfer. During a data fetch SOUT is driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| byte_rdy_i | input | 1 | Host data-byte request, edge triggered |
| stat_req_i | input | 1 | Host status/control swap request, edge triggered |
| sin_i | input | 1 | Serial data from the host |
| status_i | input | BYTE_W | Status byte offered to the host |
| sout_o | output | 1 | Serial data to the host |
| sout_oe_o | output | 1 | Driver enable for sout_o |
| sck_o | output | 1 | Serial clock generated by the block |
| sck_oe_o | output | 1 | Driver enable for sck_o |
| bus_act_n_o | output | 1 | Low while a transfer runs |
| rx_data_o | output | BYTE_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| rx_is_ctrl_o | output | 1 | 1 when rx_data_o came from a swap, 0 for data |
| init_done_o | output | 1 | First swap since reset has completed |

## Verification
The bench builds the block with BYTE_W=8, HALF_DIV=2 and SYNC_STAGES=2. A whole transfer therefore takes about 35 clocks. That is short enough for a host model driven by SCK to overlap request edges with running transfers, raise both requests in the same cycle, and abort a swap with reset mid-byte. It also allows a few dozen random data and control exchanges inside the run.

// File: rtl/hsh_pkg.sv
package hsh_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } hsh_state_e;

  typedef enum logic {
    XK_DATA = 1'b0,
    XK_CTRL = 1'b1
  } hsh_kind_e;

  // Grant vector {ctrl, data}: a pending swap always wins; data needs permission.
  function automatic logic [1:0] hsh_grant(input logic pend_data,
                                           input logic pend_ctrl,
                                           input logic allow_data);
    logic [1:0] g;
    g[1] = pend_ctrl;
    g[0] = pend_data & allow_data & ~pend_ctrl;
    return g;
  endfunction

endpackage

// File: rtl/hsh_req_sync.sv
module hsh_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic rise_o
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], req_i};
  end

  assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/hsh_sck_gen.sv
module hsh_sck_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick_o = run_i && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run_i || tick_o) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hsh_shifter.sv
module hsh_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         sin_i,
  output logic         sout_bit_o,
  output logic [W-1:0] rx_o,
  output logic         last_o
);
  localparam int BCW = (W > 1) ? $clog2(W) : 1;
  localparam logic [BCW-1:0] LAST_BIT = BCW'(W - 1);

  logic [W-1:0]   tx_q;
  logic [W-1:0]   rx_q;
  logic [BCW-1:0] bcnt_q;

  function automatic logic [W-1:0] take_bit(input logic [W-1:0] r, input logic b);
    return {r[W-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      bcnt_q <= '0;
    end else if (load_i) begin
      tx_q   <= load_val_i;
      rx_q   <= '0;
      bcnt_q <= '0;
    end else begin
      if (rise_i) rx_q <= take_bit(rx_q, sin_i);
      if (fall_i) begin
        tx_q   <= take_bit(tx_q, 1'b0);
        bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end

  assign sout_bit_o = tx_q[W-1];
  assign rx_o       = rx_q;
  assign last_o     = (bcnt_q == LAST_BIT);
endmodule

// File: rtl/hsh_arbiter.sv
module hsh_arbiter
  import hsh_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      data_rise_i,
  input  logic      ctrl_rise_i,
  input  logic      allow_data_i,
  input  logic      take_i,
  output logic      req_o,
  output hsh_kind_e kind_o
);
  logic       pend_d_q, pend_c_q;
  logic [1:0] grant;

  assign grant  = hsh_grant(pend_d_q, pend_c_q, allow_data_i);
  assign req_o  = |grant;
  assign kind_o = grant[1] ? XK_CTRL : XK_DATA;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_d_q <= 1'b0;
      pend_c_q <= 1'b0;
    end else begin
      pend_c_q <= ctrl_rise_i | (pend_c_q & ~(take_i & grant[1]));
      pend_d_q <= data_rise_i | (pend_d_q & ~(take_i & grant[0]));
    end
  end
endmodule

// File: rtl/hsh_ctrl.sv
module hsh_ctrl
  import hsh_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int HALF_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_rdy_i,
  input  logic              stat_req_i,
  input  logic              sin_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              sout_o,
  output logic              sout_oe_o,
  output logic              sck_o,
  output logic              sck_oe_o,
  output logic              bus_act_n_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_is_ctrl_o,
  output logic              init_done_o
);
  localparam int NREQ = 2;  // index 0: data byte, index 1: status/control swap

  logic [NREQ-1:0] req_lvl, req_rise;
  assign req_lvl = {stat_req_i, byte_rdy_i};

  for (genvar g = 0; g < NREQ; g++) begin : g_sync
    hsh_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req_lvl[g]),
      .rise_o (req_rise[g])
    );
  end

  hsh_state_e        state_q;
  hsh_kind_e         kind_q, arb_kind;
  logic              sck_q, init_done_q;
  logic              arb_req, tick, shifting, last_bit, tx_bit;
  logic [BYTE_W-1:0] rx_shift, load_val;

  // Named internal events, also observed by the bound checker
  logic start_evt, sck_rise_evt, sck_fall_evt, done_evt;

  assign shifting     = (state_q == ST_SHIFT);
  assign start_evt    = (state_q == ST_IDLE) && arb_req;
  assign sck_rise_evt = tick && !sck_q;
  assign sck_fall_evt = tick && sck_q;
  assign done_evt     = sck_fall_evt && last_bit;
  assign load_val     = (arb_kind == XK_CTRL) ? status_i : '0;

  hsh_arbiter u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .data_rise_i  (req_rise[0]),
    .ctrl_rise_i  (req_rise[1]),
    .allow_data_i (init_done_q),
    .take_i       (start_evt),
    .req_o        (arb_req),
    .kind_o       (arb_kind)
  );

  hsh_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (shifting),
    .tick_o (tick)
  );

  hsh_shifter #(.W(BYTE_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start_evt),
    .load_val_i (load_val),
    .rise_i     (sck_rise_evt),
    .fall_i     (sck_fall_evt),
    .sin_i      (sin_i),
    .sout_bit_o (tx_bit),
    .rx_o       (rx_shift),
    .last_o     (last_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      kind_q       <= XK_DATA;
      sck_q        <= 1'b0;
      init_done_q  <= 1'b0;
      rx_valid_o   <= 1'b0;
      rx_is_ctrl_o <= 1'b0;
      rx_data_o    <= '0;
    end else begin
      rx_valid_o <= 1'b0;
      if (start_evt) begin
        state_q <= ST_SHIFT;
        kind_q  <= arb_kind;
        sck_q   <= 1'b0;
      end else if (shifting && tick) begin
        sck_q <= ~sck_q;
        if (done_evt) begin
          state_q      <= ST_IDLE;
          rx_valid_o   <= 1'b1;
          rx_is_ctrl_o <= (kind_q == XK_CTRL);
          rx_data_o    <= rx_shift;
          if (kind_q == XK_CTRL) init_done_q <= 1'b1;
        end
      end
    end
  end

  assign sck_o       = sck_q;
  assign sck_oe_o    = shifting;
  assign sout_oe_o   = shifting;
  assign sout_o      = shifting & tx_bit;
  assign bus_act_n_o = ~shifting;
  assign init_done_o = init_done_q;
endmodule

// File: rtl/hsh_ctrl_chk.sv
module hsh_ctrl_chk #(
  parameter int BYTE_W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic sck_o,
  input logic sck_oe_o,
  input logic sout_o,
  input logic bus_act_n_o,
  input logic rx_valid_o,
  input logic rx_is_ctrl_o,
  input logic init_done_o,
  input logic start_evt,
  input logic sck_rise_evt,
  input logic done_evt
);
  logic [7:0] rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rise_cnt <= '0;
    else if (start_evt)    rise_cnt <= '0;
    else if (sck_rise_evt) rise_cnt <= rise_cnt + 1'b1;
  end

  assert_sck_low_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_oe_o |-> !sck_o);

  assert_eight_pulses_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (rise_cnt == 8'(BYTE_W)));

  assert_active_on_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !bus_act_n_o);

  assert_release_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (bus_act_n_o && !sck_oe_o));

  assert_sout_stable_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o && $past(sck_o)) |-> $stable(sout_o));

  assert_valid_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  assert_init_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |=> init_done_o);

  assert_init_with_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done_o) |-> (rx_valid_o && rx_is_ctrl_o));

  assert_data_after_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_is_ctrl_o) |-> init_done_o);
endmodule

bind hsh_ctrl hsh_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sck_o        (sck_o),
  .sck_oe_o     (sck_oe_o),
  .sout_o       (sout_o),
  .bus_act_n_o  (bus_act_n_o),
  .rx_valid_o   (rx_valid_o),
  .rx_is_ctrl_o (rx_is_ctrl_o),
  .init_done_o  (init_done_o),
  .start_evt    (start_evt),
  .sck_rise_evt (sck_rise_evt),
  .done_evt     (done_evt)
);

// File: tb/tb_hsh_ctrl.sv
module tb_hsh_ctrl;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic byte_rdy = 1'b0, stat_req = 1'b0, sin = 1'b0;
  logic [W-1:0] status = '0;
  logic sout, sout_oe, sck, sck_oe, bus_act_n, rx_valid, rx_is_ctrl, init_done;
  logic [W-1:0] rx_data;

  always #2 clk = ~clk;

  hsh_ctrl #(.BYTE_W(W), .HALF_DIV(2), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .byte_rdy_i(byte_rdy), .stat_req_i(stat_req),
    .sin_i(sin), .status_i(status), .sout_o(sout), .sout_oe_o(sout_oe),
    .sck_o(sck), .sck_oe_o(sck_oe), .bus_act_n_o(bus_act_n),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_is_ctrl_o(rx_is_ctrl),
    .init_done_o(init_done)
  );

  int checks = 0, errors = 0;
  logic [W-1:0] hq [0:127];
  int hq_wr = 0, hq_rd = 0;
  logic [W-1:0] cap_q [0:127];
  int pul_q [0:127];
  int nx = 0;
  logic [W-1:0] rd_q [0:127];
  logic rc_q [0:127];
  int nrx = 0;
  int bad_valid = 0, bad_oe = 0;
  logic valid_prev = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_sout(input bit is_ctrl, input logic [W-1:0] st);
    return is_ctrl ? st : '0;
  endfunction

  // Host model: loads a byte at transfer start, changes SIN after each falling SCK
  initial begin
    forever begin
      logic [W-1:0] cur, cap;
      int pul;
      @(posedge sck_oe);
      cur = (hq_rd < hq_wr) ? hq[hq_rd] : '0;
      if (hq_rd < hq_wr) hq_rd++;
      sin = cur[W-1];
      cap = '0;
      pul = 0;
      while (sck_oe) begin
        @(posedge sck or negedge sck_oe);
        if (sck_oe && sck) begin
          cap = {cap[W-2:0], sout};
          pul++;
          @(negedge sck);
          cur = {cur[W-2:0], 1'b0};
          sin = cur[W-1];
        end
      end
      cap_q[nx] = cap;
      pul_q[nx] = pul;
      nx++;
    end
  end

  // Output monitor, sampled away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (rx_valid) begin
          rd_q[nrx] = rx_data;
          rc_q[nrx] = rx_is_ctrl;
          nrx++;
          if (valid_prev) bad_valid++;
        end
        if (sck_oe !== sout_oe || bus_act_n !== !sck_oe) bad_oe++;
        if (!sck_oe && sck) bad_oe++;
      end
      valid_prev = rx_valid;
    end
  end

  task automatic edge_req(input bit d, input bit c);
    @(negedge clk);
    if (d) byte_rdy = 1'b1;
    if (c) stat_req = 1'b1;
    repeat (4) @(negedge clk);
    byte_rdy = 1'b0;
    stat_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_rx(input int n);
    int t = 0;
    while (nrx < n && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_xfer(input int idx, input bit is_ctrl, input logic [W-1:0] rx_exp,
                             input logic [W-1:0] so_exp, input string req);
    chk(nrx > idx, req, "transfer completed", nrx, idx + 1);
    chk(rc_q[idx] == is_ctrl, req, "rx kind tag", int'(rc_q[idx]), int'(is_ctrl));
    chk(rd_q[idx] == rx_exp, req, "received byte", rd_q[idx], rx_exp);
    chk(cap_q[idx] == so_exp, req, "byte seen on SOUT", cap_q[idx], so_exp);
    chk(pul_q[idx] == W, "R4", "SCK pulse count", pul_q[idx], W);
  endtask

  initial begin
    repeat (4000) begin
      int unused_t;
      unused_t = 0;
      repeat (40) @(posedge clk);
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'h5eed1234));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(bus_act_n === 1'b1, "R1", "bus_act_n in reset", bus_act_n, 1);
    chk(sck_oe === 1'b0 && sout_oe === 1'b0, "R1", "driver enables in reset", sck_oe, 0);
    chk(sck === 1'b0 && rx_valid === 1'b0, "R1", "sck/valid in reset", sck, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(init_done === 1'b0, "R1", "init_done after reset", init_done, 0);

    // R6: data request before the first swap is deferred
    edge_req(1, 0);
    repeat (60) @(negedge clk);
    chk(nrx == 0 && bus_act_n === 1'b1, "R6", "no fetch before first swap", nrx, 0);

    // R3, R9, R7, then the deferred data byte (R6, R12)
    status = 8'h3C;
    hq[hq_wr] = 8'h96; hq_wr++;
    hq[hq_wr] = 8'hA5; hq_wr++;
    edge_req(0, 1);
    @(posedge sck);
    status = 8'hFF;  // R9: change after capture
    wait_rx(2);
    expect_xfer(0, 1'b1, 8'h96, 8'h3C, "R9");
    chk(init_done === 1'b1, "R7", "init_done after first swap", init_done, 1);
    expect_xfer(1, 1'b0, 8'hA5, 8'h00, "R6");

    // R2/R3: random exchanges
    for (int i = 0; i < 24; i++) begin
      bit c;
      logic [W-1:0] hb, st;
      c  = 1'($urandom % 2);
      hb = W'($urandom);
      st = W'($urandom);
      status = st;
      hq[hq_wr] = hb; hq_wr++;
      base = nrx;
      edge_req(!c, c);
      wait_rx(base + 1);
      expect_xfer(base, c, hb, exp_sout(c, st), c ? "R3" : "R2");
    end

    // R8: both requests in the same cycle, swap first
    status = 8'h81;
    hq[hq_wr] = 8'h5A; hq_wr++;
    hq[hq_wr] = 8'hC3; hq_wr++;
    base = nrx;
    edge_req(1, 1);
    wait_rx(base + 2);
    expect_xfer(base, 1'b1, 8'h5A, 8'h81, "R8");
    expect_xfer(base + 1, 1'b0, 8'hC3, 8'h00, "R8");

    // R11: swap request arrives during a data fetch
    status = 8'h42;
    hq[hq_wr] = 8'h0F; hq_wr++;
    hq[hq_wr] = 8'hF0; hq_wr++;
    base = nrx;
    edge_req(1, 0);
    while (bus_act_n) @(negedge clk);
    edge_req(0, 1);
    wait_rx(base + 2);
    expect_xfer(base, 1'b0, 8'h0F, 8'h00, "R11");
    expect_xfer(base + 1, 1'b1, 8'hF0, 8'h42, "R11");

    // R12: a held level starts only one transfer
    hq[hq_wr] = 8'h33; hq_wr++;
    base = nrx;
    @(negedge clk);
    byte_rdy = 1'b1;
    repeat (200) @(negedge clk);
    chk(nrx == base + 1, "R12", "transfers for held request", nrx - base, 1);
    byte_rdy = 1'b0;
    repeat (4) @(negedge clk);

    chk(bad_valid == 0, "R10", "multi-cycle rx_valid events", bad_valid, 0);
    chk(bad_oe == 0, "R5", "enable/bus-active mismatches", bad_oe, 0);

    // R7/R1: reset in the middle of a swap
    hq[hq_wr] = 8'h77; hq_wr++;
    edge_req(0, 1);
    @(posedge sck);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(bus_act_n === 1'b1 && sck_oe === 1'b0, "R1", "drivers released by reset", sck_oe, 0);
    chk(init_done === 1'b0, "R7", "init_done cleared by reset", init_done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule